// File: doc/BRIEF.md
# Indirect Flash Read Buffer Engine

This block fetches a programmed number of bytes from a serial flash and stages them in an on-chip buffer of 32-bit words. A host drains the buffer by reading a window address. The host first writes a flash start address, a byte count and a watermark in bytes, then sets the start bit. The engine issues one command to an abstracted flash byte source and takes bytes over a ready/valid handshake. It packs the bytes into words, least significant lane first, and pushes each word into the buffer. The engine stops taking bytes whenever the buffer is full, so draining by the host sets the pace of the transfer.

Progress is visible in three places: the fill level, counted in words, a sticky done bit, and a set of write-one-to-clear status bits that drive one interrupt line through a mask. A cancel request aborts the flash stream, empties the buffer and returns the engine to idle. When the host starts a second transfer while one is still running, that start is rejected and the reject is flagged. When the host reads an empty buffer, the read returns zero and the fault is flagged.

The controller has three states:
- ST_IDLE waits for a start.
- ST_ISSUE presents the flash command for one cycle.
- ST_FETCH accepts bytes.

Its transitions are:
- ST_IDLE goes to ST_ISSUE on an accepted start, meaning a non-zero count and no cancel in the same write.
- ST_ISSUE goes to ST_FETCH unconditionally, or to ST_IDLE on cancel.
- ST_FETCH goes to ST_IDLE when the last byte is taken, or on cancel.

Register word offsets are:
- 0: control
- 1: start address
- 2: byte count
- 3: watermark
- 4: status
- 5: mask
- 6: level
- 7: window

Top module: `ind_read_engine`

## Requirements
- R1: After reset the control, level and status registers read 0, irq is low and no flash command is presented.
- R2: A start (control bit 0) with a non-zero count presents fl_cmd_valid for exactly one cycle, carrying the programmed address and count. Stream byte i lands in lane i mod 4 (bits 8*(i mod 4)+7 down to 8*(i mod 4)) of a word, and words leave the window in stream order.
- R3: When the count is not a multiple of 4, the last word carries the leftover bytes in its low lanes and zeros in the unused upper lanes.
- R4: The level register (offset 6, bits 15:0) reports the number of 32-bit words held in the buffer.
- R5: fl_data_ready is low whenever the buffer is full. No byte is lost or duplicated, and fetching resumes as the host drains the buffer.
- R6: When the last byte is placed in the buffer, done (control bit 5) and complete (status bit 2) both set. Writing 1 to control bit 5 clears done. Control bit 4 reads 1 while a transfer is running.
- R7: With a non-zero watermark, status bit 6 sets when the level in bytes (words × 4) becomes greater than or equal to the watermark. With the watermark at 0 it never sets.
- R8: A start written while a transfer is running sets status bit 3 and leaves the running transfer untouched. No new command is issued and the buffer is unchanged.
- R9: A window read of an empty buffer returns 0 and sets status bit 12.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: irq is high exactly when some status bit is set whose mask bit is 1. Writing 0 to the mask forces irq low.
- R12: A cancel (control bit 1) during a transfer pulses fl_abort, returns the engine to idle, empties the buffer and does not set done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (pops the buffer at the window address) |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Masked interrupt request |
| fl_cmd_valid | output | 1 | One-cycle flash read command |
| fl_cmd_addr | output | ADDR_W | Flash start address of the command |
| fl_cmd_len | output | CNT_W | Byte count of the command |
| fl_abort | output | 1 | One-cycle abort of the flash stream |
| fl_data | input | 8 | Flash byte |
| fl_data_valid | input | 1 | Flash byte valid |
| fl_data_ready | output | 1 | Engine accepts a flash byte |

## Verification
The bench goes after four corner cases.

- **Long read against a full buffer.** The bench issues a read longer than the buffer and holds the buffer full. A design that kept fetching while full would drop or overwrite words, and the scoreboard would see gaps in the byte pattern.
- **Odd byte count.** A 7-byte read exposes lane placement and padding. A packer that forgot to clear its accumulator would leak stale bytes into the upper lanes.
- **Start and cancel during a transfer.** A start written mid-transfer must be flagged as a reject and must not restart the stream. A cancel must empty the buffer without setting done. A design that got either wrong would show a second command, a non-zero level or a set done bit.
- **Empty-window read and watermark edge.** A read of the empty window must flag a fault and return zero. The watermark must fire at exactly half the buffer. A misplaced comparison would either miss the watermark or fire it with the watermark at zero.

// File: rtl/ird_pkg.sv
package ird_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] A_SADDR = 3'd1;
    localparam logic [REG_AW-1:0] A_COUNT = 3'd2;
    localparam logic [REG_AW-1:0] A_WMARK = 3'd3;
    localparam logic [REG_AW-1:0] A_STAT  = 3'd4;
    localparam logic [REG_AW-1:0] A_MASK  = 3'd5;
    localparam logic [REG_AW-1:0] A_LEVEL = 3'd6;
    localparam logic [REG_AW-1:0] A_WIN   = 3'd7;

    // control register bits
    localparam int C_START  = 0;
    localparam int C_CANCEL = 1;
    localparam int C_BUSY   = 4;
    localparam int C_DONE   = 5;

    // status register bits
    localparam int S_CMPL   = 2;
    localparam int S_REJECT = 3;
    localparam int S_WMARK  = 6;
    localparam int S_OVFL   = 12;
    localparam int STAT_W   = 13;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FETCH
    } eng_state_t;
endpackage

// File: rtl/ird_packer.sv
module ird_packer #(
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    byte_take,
    input  logic                    byte_last,
    input  logic [7:0]              byte_in,
    output logic [8*WORD_BYTES-1:0] word_out,
    output logic                    word_push
);
    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(WORD_BYTES - 1);

    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;

    always_comb begin
        merged = acc_q;
        merged[lane_q*8 +: 8] = byte_in;
        word_out  = merged;
        word_push = byte_take && (byte_last || lane_q == LANE_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            acc_q  <= '0;
        end else if (flush) begin
            lane_q <= '0;
            acc_q  <= '0;
        end else if (byte_take) begin
            if (word_push) begin
                lane_q <= '0;
                acc_q  <= '0;
            end else begin
                lane_q <= lane_q + 1'b1;
                acc_q  <= merged;
            end
        end
    end
endmodule

// File: rtl/ird_fifo.sv
module ird_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [LVL_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == LVL_MAX);
    assign empty   = (cnt_q == '0);
    assign level   = cnt_q;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rptr_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= (wptr_q == PTR_TOP) ? '0 : wptr_q + 1'b1;
            if (do_pop)  rptr_q <= (rptr_q == PTR_TOP) ? '0 : rptr_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ind_read_engine.sv
module ind_read_engine
    import ird_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              fl_cmd_valid,
    output logic [ADDR_W-1:0] fl_cmd_addr,
    output logic [CNT_W-1:0]  fl_cmd_len,
    output logic              fl_abort,
    input  logic [7:0]        fl_data,
    input  logic              fl_data_valid,
    output logic              fl_data_ready
);
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int LVL_W      = $clog2(DEPTH + 1);

    eng_state_t state_q, state_d;

    logic [ADDR_W-1:0] saddr_q;
    logic [CNT_W-1:0]  count_q, wmark_q, remain_q;
    logic [STAT_W-1:0] stat_q, mask_q, stat_set;
    logic              done_q, wm_hit_q;

    logic              wr_ctrl, start_req, cancel_req, cancel_now;
    logic              accept_start, reject, busy, byte_take, last_byte, xfer_end;
    logic              win_rd, fifo_pop, underflow, wm_hit;
    logic [WORD_W-1:0] pk_word, fifo_rdata;
    logic              pk_push, fifo_full, fifo_empty;
    logic [LVL_W-1:0]  fifo_level;
    logic [31:0]       lvl_bytes;

    // request decode
    assign busy         = (state_q != ST_IDLE);
    assign wr_ctrl      = reg_wr_en && (reg_addr == A_CTRL);
    assign start_req    = wr_ctrl && reg_wdata[C_START];
    assign cancel_req   = wr_ctrl && reg_wdata[C_CANCEL];
    assign cancel_now   = cancel_req && busy;
    assign accept_start = start_req && !busy && !cancel_req && (count_q != '0);
    assign reject       = start_req && busy && !cancel_req;
    assign byte_take    = fl_data_valid && fl_data_ready;
    assign last_byte    = (remain_q == CNT_W'(1));
    assign xfer_end     = byte_take && last_byte && !cancel_now;
    assign win_rd       = reg_rd_en && (reg_addr == A_WIN);
    assign fifo_pop     = win_rd && !fifo_empty;
    assign underflow    = win_rd && fifo_empty;
    assign lvl_bytes    = 32'(fifo_level) << 2;
    assign wm_hit       = (wmark_q != '0) && (lvl_bytes >= 32'(wmark_q));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept_start) state_d = ST_ISSUE;
            ST_ISSUE: state_d = cancel_now ? ST_IDLE : ST_FETCH;
            ST_FETCH: if (cancel_now || xfer_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        fl_cmd_valid  = 1'b0;
        fl_data_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: fl_cmd_valid = 1'b1;
            ST_FETCH: fl_data_ready = !fifo_full;
            default:  ;
        endcase
    end

    assign fl_cmd_addr = saddr_q;
    assign fl_cmd_len  = count_q;
    assign fl_abort    = cancel_now;

    ird_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cancel_now),
        .byte_take (byte_take),
        .byte_last (last_byte),
        .byte_in   (fl_data),
        .word_out  (pk_word),
        .word_push (pk_push)
    );

    ird_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cancel_now),
        .push  (pk_push && !cancel_now),
        .wdata (pk_word),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_comb begin
        stat_set = '0;
        stat_set[S_CMPL]   = xfer_end;
        stat_set[S_REJECT] = reject;
        stat_set[S_WMARK]  = wm_hit && !wm_hit_q;
        stat_set[S_OVFL]   = underflow;
    end

    // programming registers, status and progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saddr_q  <= '0;
            count_q  <= '0;
            wmark_q  <= '0;
            stat_q   <= '0;
            mask_q   <= '0;
            done_q   <= 1'b0;
            wm_hit_q <= 1'b0;
            remain_q <= '0;
        end else begin
            wm_hit_q <= wm_hit;
            if (reg_wr_en) begin
                unique case (reg_addr)
                    A_SADDR: saddr_q <= reg_wdata[ADDR_W-1:0];
                    A_COUNT: count_q <= reg_wdata[CNT_W-1:0];
                    A_WMARK: wmark_q <= reg_wdata[CNT_W-1:0];
                    A_MASK:  mask_q  <= reg_wdata[STAT_W-1:0];
                    default: ;
                endcase
            end
            if (reg_wr_en && reg_addr == A_STAT)
                stat_q <= (stat_q & ~reg_wdata[STAT_W-1:0]) | stat_set;
            else
                stat_q <= stat_q | stat_set;
            if (xfer_end)                    done_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[C_DONE]) done_q <= 1'b0;
            if (accept_start)   remain_q <= count_q;
            else if (cancel_now) remain_q <= '0;
            else if (byte_take) remain_q <= remain_q - 1'b1;
        end
    end

    assign irq = |(stat_q & mask_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_BUSY] = busy;
                reg_rdata[C_DONE] = done_q;
            end
            A_SADDR: reg_rdata = 32'(saddr_q);
            A_COUNT: reg_rdata = 32'(count_q);
            A_WMARK: reg_rdata = 32'(wmark_q);
            A_STAT:  reg_rdata = 32'(stat_q);
            A_MASK:  reg_rdata = 32'(mask_q);
            A_LEVEL: reg_rdata = {16'h0, 16'(fifo_level)};
            A_WIN:   reg_rdata = fifo_rdata;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ird_checker.sv
module ird_checker
    import ird_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr_en,
    input logic                       reg_rd_en,
    input logic [2:0]                 reg_addr,
    input logic [31:0]                reg_wdata,
    input logic                       irq,
    input logic                       fl_cmd_valid,
    input logic                       fl_abort,
    input logic                       fl_data_ready,
    input logic                       fifo_full,
    input logic                       fifo_empty,
    input logic                       pk_push,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level,
    input logic                       done_q,
    input logic [STAT_W-1:0]          stat_q,
    input eng_state_t                 state_q
);
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fl_data_ready);

    // R5
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_push |-> !fifo_full);

    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cmd_valid |=> !fl_cmd_valid);

    // R6
    done_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> stat_q[S_CMPL]);

    // R11
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_MASK && reg_wdata[STAT_W-1:0] == '0) |=> !irq);

    // R12
    cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_abort |=> (state_q == ST_IDLE && fifo_level == '0 && !done_q));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == A_WIN && fifo_empty) |=> stat_q[S_OVFL]);
endmodule

bind ind_read_engine ird_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_rd_en     (reg_rd_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .irq           (irq),
    .fl_cmd_valid  (fl_cmd_valid),
    .fl_abort      (fl_abort),
    .fl_data_ready (fl_data_ready),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty),
    .pk_push       (pk_push),
    .fifo_level    (fifo_level),
    .done_q        (done_q),
    .stat_q        (stat_q),
    .state_q       (state_q)
);

// File: tb/ind_read_engine_bench.sv
module ind_read_engine_bench;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;
    logic              fl_cmd_valid, fl_abort, fl_data_ready;
    logic [ADDR_W-1:0] fl_cmd_addr;
    logic [CNT_W-1:0]  fl_cmd_len;
    logic [7:0]        fl_data = '0;
    logic              fl_data_valid = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] exp_q [$];

    // flash model state
    int          fm_rem = 0;
    logic [31:0] fm_addr = '0;
    logic        fm_hs = 1'b0;
    int          cmd_count = 0;
    int          abort_count = 0;
    logic [31:0] cmd_addr_seen = '0;
    int          cmd_len_seen = 0;

    always #4 clk = ~clk;

    ind_read_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_ind_read_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_rd_en     (reg_rd_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq           (irq),
        .fl_cmd_valid  (fl_cmd_valid),
        .fl_cmd_addr   (fl_cmd_addr),
        .fl_cmd_len    (fl_cmd_len),
        .fl_abort      (fl_abort),
        .fl_data       (fl_data),
        .fl_data_valid (fl_data_valid),
        .fl_data_ready (fl_data_ready)
    );

    function automatic logic [7:0] pat(logic [31:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    // flash byte source
    initial begin
        forever begin
            @(negedge clk);
            if (fm_hs) begin
                fm_addr = fm_addr + 1;
                fm_rem  = fm_rem - 1;
            end
            fm_hs = 1'b0;
            #1;
            if (fl_cmd_valid) begin
                cmd_count++;
                cmd_addr_seen = fl_cmd_addr;
                cmd_len_seen  = int'(fl_cmd_len);
                fm_addr = fl_cmd_addr;
                fm_rem  = int'(fl_cmd_len);
            end
            if (fl_abort) begin
                abort_count++;
                fm_rem = 0;
            end
            fl_data_valid = (fm_rem > 0);
            fl_data = pat(fm_addr);
            #1;
            fm_hs = fl_data_valid && fl_data_ready;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #3;
        d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    // scoreboard driver: queue expected words for a read
    task automatic push_expected(input logic [31:0] a, input int len);
        for (int w = 0; w < (len + 3) / 4; w++) begin
            logic [31:0] word = '0;
            for (int b = 0; b < 4; b++)
                if (w * 4 + b < len) word[b*8 +: 8] = pat(a + 32'(w * 4 + b));
            exp_q.push_back(word);
        end
    endtask

    // monitor: pop words from the window and compare against the queue
    task automatic drain(input int n, input string req);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            d = '0;
            for (int t = 0; t < 500 && d[15:0] == 0; t++) reg_rd(3'd6, d);
            reg_rd(3'd7, d);
            chk(req, d, exp_q.pop_front());
        end
    endtask

    task automatic wait_done();
        logic [31:0] d;
        d = '0;
        for (int t = 0; t < 2000 && !d[5]; t++) reg_rd(3'd0, d);
    endtask

    task automatic start_read(input logic [31:0] a, input int len);
        reg_wr(3'd1, a);
        reg_wr(3'd2, 32'(len));
        reg_wr(3'd0, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(3'd0, d); chk("R1 ctrl", d, 0);
        reg_rd(3'd6, d); chk("R1 level", d, 0);
        reg_rd(3'd4, d); chk("R1 status", d, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 cmd", 32'(fl_cmd_valid), 0);

        // R2 aligned 8-byte read
        reg_wr(3'd3, 0);
        push_expected(32'h100, 8);
        start_read(32'h100, 8);
        wait_done();
        chk("R2 cmd count", 32'(cmd_count), 1);
        chk("R2 cmd addr", cmd_addr_seen, 32'h100);
        chk("R2 cmd len", 32'(cmd_len_seen), 8);
        reg_rd(3'd6, d); chk("R4 level words", d, 2);
        reg_rd(3'd4, d); chk("R6 complete only, R7 no watermark at 0", d, 32'h4);
        drain(2, "R2 word order");
        reg_rd(3'd6, d); chk("R4 level after drain", d, 0);
        reg_wr(3'd0, 32'h20);
        reg_rd(3'd0, d); chk("R6 done cleared", d, 0);
        reg_wr(3'd4, 32'h0);
        reg_rd(3'd4, d); chk("R10 zero write keeps", d, 32'h4);
        reg_wr(3'd4, 32'h4);
        reg_rd(3'd4, d); chk("R10 W1C", d, 0);

        // R3 odd count
        push_expected(32'h23, 7);
        start_read(32'h23, 7);
        wait_done();
        reg_rd(3'd6, d); chk("R4 level odd", d, 2);
        drain(2, "R3 padded tail");
        reg_wr(3'd0, 32'h20);
        reg_wr(3'd4, 32'hFFFF);

        // R5 / R7 long read with watermark at half capacity
        reg_wr(3'd3, DEPTH * 4 / 2);
        push_expected(32'h40, 80);
        start_read(32'h40, 80);
        repeat (200) @(negedge clk);
        reg_rd(3'd6, d); chk("R5 buffer full level", d, DEPTH);
        chk("R5 ready low when full", 32'(fl_data_ready), 0);
        reg_rd(3'd0, d); chk("R6 busy bit", d, 32'h10);
        reg_rd(3'd4, d); chk("R7 watermark set", d & 32'h40, 32'h40);
        drain(20, "R5 no loss");
        wait_done();
        reg_rd(3'd4, d); chk("R6 complete", d & 32'h4, 32'h4);

        // R11 mask
        reg_wr(3'd5, 0);
        chk("R11 mask zero", 32'(irq), 0);
        reg_wr(3'd5, 32'h40);
        chk("R11 masked bit", 32'(irq), 1);
        reg_wr(3'd4, 32'hFFFF);
        chk("R10 clear drops irq", 32'(irq), 0);
        reg_wr(3'd5, 0);
        reg_wr(3'd0, 32'h20);

        // R8 reject, R12 cancel
        reg_wr(3'd3, 0);
        start_read(32'h0, 200);
        repeat (60) @(negedge clk);
        c0 = cmd_count;
        reg_wr(3'd0, 32'h1);
        reg_rd(3'd4, d); chk("R8 reject bit", d, 32'h8);
        chk("R8 no new cmd", 32'(cmd_count), 32'(c0));
        reg_rd(3'd6, d); chk("R8 buffer intact", d, DEPTH);
        c0 = abort_count;
        reg_wr(3'd0, 32'h2);
        chk("R12 abort pulse", 32'(abort_count), 32'(c0 + 1));
        reg_rd(3'd0, d); chk("R12 idle, no done", d, 0);
        reg_rd(3'd6, d); chk("R12 buffer empty", d, 0);
        reg_wr(3'd4, 32'hFFFF);

        // R9 empty pop
        reg_rd(3'd7, d); chk("R9 empty read data", d, 0);
        reg_rd(3'd4, d); chk("R9 fault bit", d, 32'h1000);
        reg_wr(3'd5, 32'h1000);
        chk("R11 fault irq", 32'(irq), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule